// File: doc/BRIEF.md
# Configurable Interrupt Input Conditioner

This block turns a group of external interrupt request pins into a single maskable processor request and one non-maskable request. Every ordinary input is first brought into the clock domain by a two-stage synchronizer. A per-source glitch filter then only accepts a new level after the synchronized pin has held it for a programmable number of samples. Each source is configured as either level sensitive or edge sensitive, and each has its own enable.

In level mode, a source requests service for as long as its filtered input stays high. This includes the case where the input is already high at the moment the source is enabled. In edge mode, a filtered low-to-high transition sets a sticky pending bit. That bit holds until software writes a one to clear it. The combined request is the OR of every enabled request, so it behaves like a shared wire: it stays high while any source still needs attention, and the handler is entered again when a late source arrives.

The non-maskable input is detected on its rising edge. A service acknowledge strobe clears the request and sets a mask. The mask is released only when the pin returns low, so a pin stuck high cannot cause the handler to be entered repeatedly. Software reaches the configuration through a small register port. Writes are synchronous and reads are combinational.

Top module: `irqc_top`

## Requirements
- R1: After reset, every register reads zero and both `irq_out` and `nmi_out` are low.
- R2: A source's filtered level changes only after its synchronized input has differed from it for N consecutive clocks. N is the source's filter field, and a field of 0 acts as 1. Shorter pulses have no effect.
- R3: For an enabled edge-mode source, a low-to-high change of the filtered level sets its pending bit. The bit remains set until a one is written to that source's bit at address 4.
- R4: A level-mode source requests service exactly while its filtered level is high. If the input is already high when the source is enabled, `irq_out` rises the cycle after the enable write.
- R5: An edge-mode source that is enabled while its input is already high does not request service until a new low-to-high transition occurs.
- R6: `irq_out` is high whenever at least one enabled source requests service. It stays high after one source is cleared if another still requests service.
- R7: If a write-one-to-clear and a new qualifying edge of the same source land on the same clock, the pending bit stays set.
- R8: Clearing a source's enable removes it from `irq_out` but keeps its pending bit. Enabling the source again brings the request back.
- R9: A rising edge of the synchronized `nmi_pin` raises `nmi_out`. `nmi_ack` clears `nmi_out` on the next clock and masks further requests until the synchronized pin is low again.
- R10: The register map is as follows.
  - Address 0 holds the enables, with bit i for source i.
  - Address 1 holds the modes, with bit i = 1 meaning edge and 0 meaning level.
  - Address 2 holds the filter lengths, packed FLT_W bits per source at bits [i*FLT_W +: FLT_W].
  - Address 3 is a read-only status word. Bit i is the pending bit for an edge source, or the filtered level for a level source. Writes to address 3 are ignored.
  - Address 4 is write-one-to-clear and reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pins | input | NSRC | External interrupt pins, active high |
| nmi_pin | input | 1 | Non-maskable request pin, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, combinational |
| nmi_ack | input | 1 | Non-maskable service acknowledge strobe |
| irq_out | output | 1 | Combined maskable interrupt request |
| nmi_out | output | 1 | Non-maskable interrupt request |

## Verification
The bench builds the block with NSRC = 4 and FLT_W = 3, which allows filter lengths from 1 to 7. This makes it possible to test pulses both shorter and longer than a four-sample filter on a single source. Four sources are enough to mix level and edge channels and to hold two requests at once while one of them is cleared. A sweep of clear writes against a freshly detected edge hits the same-clock collision exactly. A random phase then varies pins, configuration and acknowledges while a behavioural model is compared every cycle.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    typedef enum logic [2:0] {
        ADR_ENABLE = 3'd0,
        ADR_MODE   = 3'd1,
        ADR_FILTER = 3'd2,
        ADR_STATUS = 3'd3,
        ADR_CLEAR  = 3'd4
    } reg_addr_e;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] stage1;
        logic [W-1:0] stage2;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.stage1 = async_i;
        st_d.stage2 = st_q.stage1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.stage2;
endmodule

// File: rtl/irqc_chan.sv
module irqc_chan #(
    parameter int FLT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_i,
    input  logic [FLT_W-1:0] flen_i,
    input  logic             en_i,
    input  logic             edge_i,
    input  logic             clr_i,
    output logic             req_o
);
    localparam int CW = FLT_W + 1;

    typedef struct packed {
        logic             filt;
        logic [FLT_W-1:0] cnt;
        logic             pend;
    } chan_st_t;

    chan_st_t       st_d, st_q;
    logic [CW-1:0]  eff_len;
    logic           rise;

    always_comb begin
        st_d    = st_q;
        eff_len = (flen_i == '0) ? CW'(1) : {1'b0, flen_i};
        if (sync_i == st_q.filt) begin
            st_d.cnt = '0;
        end else if (({1'b0, st_q.cnt} + CW'(1)) >= eff_len) begin
            st_d.filt = sync_i;
            st_d.cnt  = '0;
        end else begin
            st_d.cnt = st_q.cnt + FLT_W'(1);
        end
        rise = st_d.filt & ~st_q.filt;
        if (clr_i) st_d.pend = 1'b0;
        if (rise && en_i && edge_i) st_d.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_o = edge_i ? st_q.pend : st_q.filt;

    // R2: the filtered level only ever moves to a value the synchronized input held
    assert_filter_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.filt != $past(st_q.filt)) |-> (st_q.filt == $past(sync_i)));

    // R3: a pending bit survives every cycle without a clear
    assert_pend_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && !clr_i) |=> st_q.pend);

    // R7: a clear colliding with a qualifying edge leaves the bit set
    assert_edge_beats_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && rise && en_i && edge_i) |=> st_q.pend);
endmodule

// File: rtl/irqc_nmi.sv
module irqc_nmi (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_i,
    input  logic ack_i,
    output logic req_o
);
    typedef struct packed {
        logic prev;
        logic pend;
        logic mask;
    } nmi_st_t;

    nmi_st_t st_d, st_q;
    logic    rise;

    always_comb begin
        st_d      = st_q;
        rise      = sync_i & ~st_q.prev;
        st_d.prev = sync_i;
        if (ack_i) begin
            st_d.pend = 1'b0;
            st_d.mask = 1'b1;
        end else begin
            if (rise && !st_q.mask) st_d.pend = 1'b1;
            if (!sync_i)            st_d.mask = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_o = st_q.pend;

    // R9: acknowledge drops the request on the next clock
    assert_ack_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> !req_o);

    // R9: while masked after service no request is presented
    assert_mask_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.mask |-> !req_o);
endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int NSRC   = 4,
    parameter int FLT_W  = 3,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   irq_pins,
    input  logic              nmi_pin,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              nmi_ack,
    output logic              irq_out,
    output logic              nmi_out
);
    localparam int FLW = NSRC * FLT_W;

    typedef struct packed {
        logic [NSRC-1:0] en;
        logic [NSRC-1:0] mode;
        logic [FLW-1:0]  flen;
    } cfg_st_t;

    cfg_st_t         st_d, st_q;
    logic [NSRC:0]   synced;
    logic [NSRC-1:0] req;
    logic [NSRC-1:0] clr;

    irqc_sync #(.W(NSRC + 1)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({nmi_pin, irq_pins}),
        .sync_o  (synced)
    );

    always_comb begin
        st_d = st_q;
        clr  = '0;
        if (reg_we) begin
            case (reg_addr)
                ADR_ENABLE: st_d.en   = reg_wdata[NSRC-1:0];
                ADR_MODE:   st_d.mode = reg_wdata[NSRC-1:0];
                ADR_FILTER: st_d.flen = reg_wdata[FLW-1:0];
                ADR_CLEAR:  clr       = reg_wdata[NSRC-1:0];
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_chan
        irqc_chan #(.FLT_W(FLT_W)) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .sync_i (synced[i]),
            .flen_i (st_q.flen[i*FLT_W +: FLT_W]),
            .en_i   (st_q.en[i]),
            .edge_i (st_q.mode[i]),
            .clr_i  (clr[i]),
            .req_o  (req[i])
        );
    end

    irqc_nmi u_nmi (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_i (synced[NSRC]),
        .ack_i  (nmi_ack),
        .req_o  (nmi_out)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADR_ENABLE: reg_rdata[NSRC-1:0] = st_q.en;
            ADR_MODE:   reg_rdata[NSRC-1:0] = st_q.mode;
            ADR_FILTER: reg_rdata[FLW-1:0]  = st_q.flen;
            ADR_STATUS: reg_rdata[NSRC-1:0] = req;
            default:    ;
        endcase
    end

    assign irq_out = |(st_q.en & req);

    // R6: the combined request is never raised with every source disabled
    assert_irq_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (st_q.en != '0));

    // R10: a write to the status address leaves the configuration untouched
    assert_status_readonly_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 3'd3) |=> (st_q == $past(st_q)));
endmodule

// File: tb/irqc_top_test.sv
module irqc_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int NSRC  = 4;
    localparam int FLT_W = 3;
    localparam int DW    = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] irq_pins = '0;
    logic            nmi_pin = 1'b0;
    logic            reg_we = 1'b0;
    logic [2:0]      reg_addr = 3'd3;
    logic [DW-1:0]   reg_wdata = '0;
    logic [DW-1:0]   reg_rdata;
    logic            nmi_ack = 1'b0;
    logic            irq_out;
    logic            nmi_out;

    int vectors = 0;
    int fails = 0;
    int cycles = 0;
    bit cmp_on = 1'b0;

    irqc_top #(.NSRC(NSRC), .FLT_W(FLT_W), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .irq_pins(irq_pins), .nmi_pin(nmi_pin),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .nmi_ack(nmi_ack), .irq_out(irq_out), .nmi_out(nmi_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference model
    bit m_s1[NSRC], m_s2[NSRC], m_filt[NSRC], m_pend[NSRC];
    int m_cnt[NSRC];
    bit [NSRC-1:0] m_en, m_mode;
    bit [NSRC*FLT_W-1:0] m_flen;
    bit m_n1, m_n2, m_nprev, m_npend, m_nmask;

    function automatic bit m_req(int i);
        return m_mode[i] ? m_pend[i] : m_filt[i];
    endfunction

    function automatic bit m_irq();
        bit r = 0;
        for (int i = 0; i < NSRC; i++) r |= m_en[i] & m_req(i);
        return r;
    endfunction

    function automatic logic [DW-1:0] m_read(logic [2:0] a);
        logic [DW-1:0] r = '0;
        case (a)
            3'd0: r[NSRC-1:0] = m_en;
            3'd1: r[NSRC-1:0] = m_mode;
            3'd2: r[NSRC*FLT_W-1:0] = m_flen;
            3'd3: for (int i = 0; i < NSRC; i++) r[i] = m_req(i);
            default: r = '0;
        endcase
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NSRC; i++) begin
                m_s1[i] = 0; m_s2[i] = 0; m_filt[i] = 0; m_pend[i] = 0; m_cnt[i] = 0;
            end
            m_en = '0; m_mode = '0; m_flen = '0;
            m_n1 = 0; m_n2 = 0; m_nprev = 0; m_npend = 0; m_nmask = 0;
        end else begin
            for (int i = 0; i < NSRC; i++) begin
                int len;
                bit nf;
                bit clr;
                len = int'(m_flen[i*FLT_W +: FLT_W]);
                if (len == 0) len = 1;
                nf = m_filt[i];
                if (m_s2[i] == m_filt[i]) m_cnt[i] = 0;
                else if (m_cnt[i] + 1 >= len) begin nf = m_s2[i]; m_cnt[i] = 0; end
                else m_cnt[i] = m_cnt[i] + 1;
                clr = reg_we && reg_addr == 3'd4 && reg_wdata[i];
                if (clr) m_pend[i] = 0;
                if (nf && !m_filt[i] && m_en[i] && m_mode[i]) m_pend[i] = 1;
                m_filt[i] = nf;
                m_s2[i] = m_s1[i];
                m_s1[i] = irq_pins[i];
            end
            if (nmi_ack) begin
                m_npend = 0; m_nmask = 1;
            end else begin
                if (m_n2 && !m_nprev && !m_nmask) m_npend = 1;
                if (!m_n2) m_nmask = 0;
            end
            m_nprev = m_n2; m_n2 = m_n1; m_n1 = nmi_pin;
            if (reg_we) begin
                case (reg_addr)
                    3'd0: m_en = reg_wdata[NSRC-1:0];
                    3'd1: m_mode = reg_wdata[NSRC-1:0];
                    3'd2: m_flen = reg_wdata[NSRC*FLT_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            chk("R6 irq_out", {31'b0, irq_out}, {31'b0, m_irq()});
            chk("R9 nmi_out", {31'b0, nmi_out}, {31'b0, m_npend});
            chk("R10 rdata", reg_rdata, m_read(reg_addr));
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [2:0] a, logic [DW-1:0] d);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 0; reg_addr = 3'd3; reg_wdata = '0;
    endtask

    task automatic rd_chk(string req, logic [2:0] a, logic [DW-1:0] exp);
        reg_addr = a; #1;
        chk(req, reg_rdata, exp);
        reg_addr = 3'd3;
    endtask

    initial begin
        tick(3);
        // R1 reset state
        for (int a = 0; a < 5; a++) rd_chk("R1 reset reg", 3'(a), '0);
        chk("R1 reset irq", {31'b0, irq_out}, 0);
        chk("R1 reset nmi", {31'b0, nmi_out}, 0);
        rst_n = 1;
        cmp_on = 1;
        tick(2);

        // source 0 edge len1, 1 level len2, 2 edge len4, 3 level len0
        wr(3'd2, 32'd273);
        wr(3'd1, 32'b0101);
        rd_chk("R10 filter packing", 3'd2, 32'd273);
        rd_chk("R10 mode reg", 3'd1, 32'b0101);

        // R5: edge source already high when enabled stays quiet
        irq_pins[0] = 1; tick(8);
        wr(3'd0, 32'b0001);
        tick(4);
        chk("R5 no fire on enable", {31'b0, irq_out}, 0);
        irq_pins[0] = 0; tick(6);
        irq_pins[0] = 1; tick(6);
        chk("R3 fresh edge fires", {31'b0, irq_out}, 1);
        irq_pins[0] = 0; tick(6);
        chk("R3 pending sticky after release", {31'b0, irq_out}, 1);
        wr(3'd4, 32'b0001); tick(1);
        chk("R3 cleared by write-one", {31'b0, irq_out}, 0);

        // R4: level source already high fires on the cycle after enable
        irq_pins[1] = 1; tick(8);
        reg_we = 1; reg_addr = 3'd0; reg_wdata = 32'b0011;
        @(negedge clk);
        reg_we = 0; reg_addr = 3'd3;
        chk("R4 level fires on enable", {31'b0, irq_out}, 1);
        irq_pins[1] = 0; tick(6);
        chk("R4 level follows input low", {31'b0, irq_out}, 0);

        // R2: glitch on source 2 (filter 4)
        wr(3'd0, 32'b0100);
        irq_pins[2] = 1; tick(2); irq_pins[2] = 0; tick(10);
        chk("R2 short glitch rejected", {31'b0, irq_out}, 0);
        irq_pins[2] = 1; tick(10);
        chk("R2 long pulse accepted", {31'b0, irq_out}, 1);

        // R8: disable keeps pending
        wr(3'd0, 32'b0000); tick(1);
        chk("R8 disabled masks irq", {31'b0, irq_out}, 0);
        rd_chk("R8 pending kept", 3'd3, 32'b0100);
        wr(3'd0, 32'b0100); tick(1);
        chk("R8 re-enable restores", {31'b0, irq_out}, 1);

        // R6: two requests, clear one, output stays high
        wr(3'd0, 32'b0101);
        irq_pins[0] = 1; tick(6);
        wr(3'd4, 32'b0100); tick(1);
        chk("R6 remains with other source", {31'b0, irq_out}, 1);
        wr(3'd4, 32'b0001); tick(1);
        chk("R6 drops when none left", {31'b0, irq_out}, 0);
        irq_pins[0] = 0; irq_pins[2] = 0; tick(10);

        // R7: sweep clear write against edge detection on source 0
        for (int k = 0; k < 6; k++) begin
            wr(3'd4, 32'b0001); tick(4);
            irq_pins[0] = 1;
            tick(k);
            wr(3'd4, 32'b0001);
            tick(6);
            reg_addr = 3'd3; #1;
            chk("R7 clear vs edge", {31'b0, reg_rdata[0]}, {31'b0, (k <= 2)});
            irq_pins[0] = 0; tick(6);
        end
        wr(3'd4, 32'hF);

        // R10: writes to status ignored, clear address reads zero
        wr(3'd3, 32'hFFFF_FFFF); tick(1);
        rd_chk("R10 enable unchanged", 3'd0, 32'b0101);
        rd_chk("R10 clear reads zero", 3'd4, 32'd0);

        // R9: non-maskable path
        nmi_pin = 1; tick(5);
        chk("R9 nmi raised", {31'b0, nmi_out}, 1);
        nmi_ack = 1; tick(1); nmi_ack = 0;
        chk("R9 ack clears", {31'b0, nmi_out}, 0);
        tick(12);
        chk("R9 stuck pin no re-entry", {31'b0, nmi_out}, 0);
        nmi_pin = 0; tick(5); nmi_pin = 1; tick(5);
        chk("R9 new edge after release", {31'b0, nmi_out}, 1);
        nmi_ack = 1; tick(1); nmi_ack = 0; nmi_pin = 0; tick(4);

        // random phase
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(0, 5) == 0) irq_pins = NSRC'($urandom);
            if ($urandom_range(0, 9) == 0) nmi_pin = ~nmi_pin;
            nmi_ack = ($urandom_range(0, 15) == 0);
            if ($urandom_range(0, 19) == 0) begin
                reg_we = 1; reg_addr = 3'($urandom_range(0, 4)); reg_wdata = $urandom;
            end else begin
                reg_we = 0; reg_addr = 3'($urandom_range(0, 4)); reg_wdata = '0;
            end
            tick(1);
        end
        reg_we = 0; nmi_ack = 0;
        tick(2);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule